// File: doc/BRIEF.md
# Vector Load Zero-Test Length Truncation

This block steps through the elements of a vector load one at a time, issues a memory request for each, and tests every returned word against zero. The first zero word ends the vector: the active vector length is cut at that element and no further requests go out. For each element the block decides whether the returned word is written to its destination register. The register file and memory sit outside and are reached through plain write and request/response ports.

Two truncation flavours exist. In the dropping flavour the zero element is discarded and the length becomes the count of elements before it. In the keeping flavour the zero element is written and counted. A pointer-chasing mode takes each element's address from the word loaded by the previous element plus a fixed link offset. Each loaded word then lands one register further on and serves as the next pointer. A write-back option in that mode also returns the address used for each access to the register that held its pointer.

Top module: `ff_vl_trunc`

## Requirements
- R1: After reset, `mem_req`, `wb_valid`, `upd_valid` and `done` are low and `vl_out` is 0.
- R2: On `start` the working length is the smaller of `remaining` and MAXVL (8 by default). A working length of 0 raises `done` one cycle later with `vl_out` = 0 and issues no request.
- R3: With `chain_mode` low, element i is fetched from `base_addr` + 4*i. Requests go out in element order, each a one-cycle pulse, and the next one only after the response to the previous one.
- R4: When no returned word is zero, every element i is written with `wb_idx` = i and its word, and `vl_out` equals the working length.
- R5: With `incl_mode` low, the first zero word at element k is not written, and `vl_out` = k.
- R6: With `incl_mode` high, the first zero word at element k is written, and `vl_out` = k+1.
- R7: After the element holding the first zero word, no memory request is issued and no register write occurs for the rest of the vector.
- R8: With `chain_mode` high, the address of element i is p_i + 8, where p_0 = `base_addr` and p_(i+1) is the word returned for element i. That word is written to register i+1.
- R9: With `chain_mode` and `upd_mode` high, every element that is written also writes its access address to register i (`upd_idx` = i, `upd_data` = p_i + 8). This write happens in the same cycle as the data write to register i+1.
- R10: `done` is a one-cycle pulse. It coincides with the write of the last element, if that element is written. `vl_out` changes only in a `done` cycle and then holds until the next completion.
- R11: `start` while a vector is in progress is ignored. A `mem_rsp_valid` that arrives while no request is outstanding produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a vector when idle |
| remaining | input | CNT_W | Element count still to process |
| incl_mode | input | 1 | 1: keep and count the zero element |
| chain_mode | input | 1 | 1: pointer-chasing addresses |
| upd_mode | input | 1 | 1: write access address back (chain mode) |
| base_addr | input | WORD_W | Array base, or first pointer in chain mode |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | WORD_W | Request address |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | WORD_W | Returned word |
| wb_valid | output | 1 | Element data write |
| wb_idx | output | IDX_W | Destination register index |
| wb_data | output | WORD_W | Data written |
| upd_valid | output | 1 | Address write-back |
| upd_idx | output | IDX_W | Register receiving the address |
| upd_data | output | WORD_W | Address written back |
| done | output | 1 | Vector complete pulse |
| vl_out | output | IDX_W | Resulting vector length |

## Verification
The data write to register i+1 and the address write-back to register i fall in the same cycle when pointer chasing runs with write-back on. The chained walks exercise this with write-back on, and a scoreboard matches both queues element by element. The end-of-vector pulse also shares its cycle with the final element's write, including the case where that element is the zero that ends the walk. The bench checks that the final write is popped in that cycle and that nothing is left in any queue afterwards.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2
  } ffvl_state_e;
endpackage

// File: rtl/ffvl_len_clip.sv
module ffvl_len_clip #(
  parameter int CNT_W = 16,
  parameter int MAXVL = 8,
  parameter int IDX_W = 4
) (
  input  logic [CNT_W-1:0] remaining,
  output logic [IDX_W-1:0] vl
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAXVL);

  always_comb begin
    if (remaining > CAP) vl = IDX_W'(MAXVL);
    else                 vl = remaining[IDX_W-1:0];
  end
endmodule

// File: rtl/ffvl_addr_gen.sv
module ffvl_addr_gen #(
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 4,
  parameter int ELEM_BYTES = 4,
  parameter int LINK_OFS   = 8
) (
  input  logic              chain,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] ptr,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] addr
);
  localparam logic [WORD_W-1:0] STRIDE = WORD_W'(ELEM_BYTES);
  localparam logic [WORD_W-1:0] LINK   = WORD_W'(LINK_OFS);

  logic [WORD_W-1:0] strided;
  logic [WORD_W-1:0] linked;

  // stride is a power of two in typical use; a multiply keeps it general
  assign strided = base + (WORD_W'(idx) * STRIDE);
  assign linked  = ptr + LINK;
  assign addr    = chain ? linked : strided;
endmodule

// File: rtl/ffvl_judge.sv
module ffvl_judge #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic [WORD_W-1:0] data,
  input  logic              incl,
  input  logic              chain,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  vl,
  output logic              keep,
  output logic              stop,
  output logic              last,
  output logic [IDX_W-1:0]  vl_final,
  output logic [IDX_W-1:0]  dst_idx
);
  logic              is_zero;
  logic [IDX_W-1:0]  idx_p1;

  assign is_zero = (data == '0);
  assign idx_p1  = idx + IDX_W'(1);
  assign keep    = !is_zero || incl;
  assign stop    = is_zero;
  assign last    = (idx_p1 == vl);
  assign dst_idx = chain ? idx_p1 : idx;

  always_comb begin
    if (is_zero) vl_final = incl ? idx_p1 : idx;
    else         vl_final = vl;
  end
endmodule

// File: rtl/ff_vl_trunc.sv
module ff_vl_trunc #(
  parameter int WORD_W     = 32,
  parameter int CNT_W      = 16,
  parameter int MAXVL      = 8,
  parameter int ELEM_BYTES = 4,
  parameter int LINK_OFS   = 8,
  parameter int IDX_W      = $clog2(MAXVL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  remaining,
  input  logic              incl_mode,
  input  logic              chain_mode,
  input  logic              upd_mode,
  input  logic [WORD_W-1:0] base_addr,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [WORD_W-1:0] wb_data,
  output logic              upd_valid,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [WORD_W-1:0] upd_data,
  output logic              done,
  output logic [IDX_W-1:0]  vl_out
);
  import ffvl_pkg::*;

  ffvl_state_e       state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  vl_cur;
  logic [WORD_W-1:0] ptr;
  logic [WORD_W-1:0] base_q;
  logic              incl_q;
  logic              chain_q;
  logic              upd_q;

  logic [IDX_W-1:0]  vl_clip;
  logic [WORD_W-1:0] addr_c;
  logic              j_keep;
  logic              j_stop;
  logic              j_last;
  logic [IDX_W-1:0]  j_vl;
  logic [IDX_W-1:0]  j_dst;

  ffvl_len_clip #(.CNT_W(CNT_W), .MAXVL(MAXVL), .IDX_W(IDX_W)) u_clip (
    .remaining (remaining),
    .vl        (vl_clip)
  );

  ffvl_addr_gen #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .ELEM_BYTES(ELEM_BYTES), .LINK_OFS(LINK_OFS)
  ) u_agen (
    .chain (chain_q),
    .base  (base_q),
    .ptr   (ptr),
    .idx   (idx),
    .addr  (addr_c)
  );

  ffvl_judge #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_judge (
    .data     (mem_rsp_data),
    .incl     (incl_q),
    .chain    (chain_q),
    .idx      (idx),
    .vl       (vl_cur),
    .keep     (j_keep),
    .stop     (j_stop),
    .last     (j_last),
    .vl_final (j_vl),
    .dst_idx  (j_dst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      vl_cur    <= '0;
      ptr       <= '0;
      base_q    <= '0;
      incl_q    <= 1'b0;
      chain_q   <= 1'b0;
      upd_q     <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      wb_valid  <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      upd_valid <= 1'b0;
      upd_idx   <= '0;
      upd_data  <= '0;
      done      <= 1'b0;
      vl_out    <= '0;
    end else begin
      mem_req   <= 1'b0;
      wb_valid  <= 1'b0;
      upd_valid <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            vl_cur  <= vl_clip;
            idx     <= '0;
            ptr     <= base_addr;
            base_q  <= base_addr;
            incl_q  <= incl_mode;
            chain_q <= chain_mode;
            upd_q   <= upd_mode;
            if (vl_clip == '0) begin
              done   <= 1'b1;
              vl_out <= '0;
            end else begin
              state <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          mem_req  <= 1'b1;
          mem_addr <= addr_c;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            wb_valid  <= j_keep;
            wb_idx    <= j_dst;
            wb_data   <= mem_rsp_data;
            upd_valid <= j_keep && chain_q && upd_q;
            upd_idx   <= idx;
            upd_data  <= mem_addr;
            if (j_stop || j_last) begin
              done   <= 1'b1;
              vl_out <= j_vl;
              state  <= ST_IDLE;
            end else begin
              idx   <= idx + IDX_W'(1);
              ptr   <= mem_rsp_data;
              state <= ST_ADDR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ff_vl_trunc_chk.sv
module ff_vl_trunc_chk #(
  parameter int MAXVL = 8,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             mem_req,
  input logic             mem_rsp_valid,
  input logic             wb_valid,
  input logic [IDX_W-1:0] wb_idx,
  input logic             upd_valid,
  input logic [IDX_W-1:0] upd_idx,
  input logic             done,
  input logic [IDX_W-1:0] vl_out
);
  logic pend;
  logic quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      quiet <= 1'b0;
    end else begin
      if (mem_req)            pend <= 1'b1;
      else if (mem_rsp_valid) pend <= 1'b0;
      if (start)              quiet <= 1'b0;
      else if (done)          quiet <= 1'b1;
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !pend);
  a_r7_quiet_after_end: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !quiet);
  a_r9_paired_write: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (wb_valid && (wb_idx == upd_idx + IDX_W'(1))));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_vl_moves_on_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(vl_out) |-> done);
  a_r10_no_req_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);
  a_r2_vl_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (vl_out <= IDX_W'(MAXVL)));
endmodule

bind ff_vl_trunc ff_vl_trunc_chk #(.MAXVL(MAXVL), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .mem_req       (mem_req),
  .mem_rsp_valid (mem_rsp_valid),
  .wb_valid      (wb_valid),
  .wb_idx        (wb_idx),
  .upd_valid     (upd_valid),
  .upd_idx       (upd_idx),
  .done          (done),
  .vl_out        (vl_out)
);

// File: tb/sim_ff_vl_trunc.sv
`timescale 1ns/1ps
module sim_ff_vl_trunc;
  localparam int W  = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   remaining = '0;
  logic          incl_mode = 1'b0, chain_mode = 1'b0, upd_mode = 1'b0;
  logic [W-1:0]  base_addr = '0;
  logic          mem_req;
  logic [W-1:0]  mem_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [W-1:0]  mem_rsp_data = '0;
  logic          wb_valid, upd_valid, done;
  logic [IW-1:0] wb_idx, upd_idx, vl_out;
  logic [W-1:0]  wb_data, upd_data;

  always #5 clk = ~clk;

  ff_vl_trunc u0 (
    .clk(clk), .rst(rst), .start(start), .remaining(remaining),
    .incl_mode(incl_mode), .chain_mode(chain_mode), .upd_mode(upd_mode),
    .base_addr(base_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_data(upd_data),
    .done(done), .vl_out(vl_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  logic [W-1:0] memm [int];
  logic [W-1:0] q_addr [$];
  int           q_wbi  [$];
  logic [W-1:0] q_wbd  [$];
  int           q_ui   [$];
  logic [W-1:0] q_ud   [$];

  function automatic logic [W-1:0] rd(input logic [W-1:0] a);
    if (memm.exists(int'(a))) return memm[int'(a)];
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder, latency of two cycles; also injects stray strobes
  logic         inject = 1'b0;
  int           lat = 0;
  logic [W-1:0] lat_a = '0;
  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (inject) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= 32'h5a5a;
    end else if (mem_req) begin
      lat   = 2;
      lat_a = mem_addr;
    end else if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(lat_a);
      end
    end
  end

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) begin
        if (q_addr.size() == 0) chk({cur_tag, " unexpected request"}, mem_addr, 'x);
        else chk({cur_tag, " address"}, mem_addr, q_addr.pop_front());
      end
      if (wb_valid) begin
        if (q_wbi.size() == 0) chk({cur_tag, " unexpected write"}, W'(wb_idx), 'x);
        else begin
          chk({cur_tag, " write index"}, W'(wb_idx), W'(q_wbi.pop_front()));
          chk({cur_tag, " write data"}, wb_data, q_wbd.pop_front());
        end
      end
      if (upd_valid) begin
        if (q_ui.size() == 0) chk({cur_tag, " unexpected update"}, W'(upd_idx), 'x);
        else begin
          chk({cur_tag, " update index"}, W'(upd_idx), W'(q_ui.pop_front()));
          chk({cur_tag, " update data"}, upd_data, q_ud.pop_front());
        end
      end
    end
  end

  task automatic run_case(input int rem, input bit inc, input bit chn, input bit upd,
                          input logic [W-1:0] base, input string tag, input bit poke);
    int vl = (rem > 8) ? 8 : rem;
    int vexp = vl;
    logic [W-1:0] ptr = base;
    int waited = 0;
    cur_tag = tag;
    for (int i = 0; i < vl; i++) begin
      logic [W-1:0] a = chn ? ptr + 8 : base + W'(4 * i);
      logic [W-1:0] d = rd(a);
      q_addr.push_back(a);
      if (d != 0 || inc) begin
        q_wbi.push_back(chn ? i + 1 : i);
        q_wbd.push_back(d);
        if (chn && upd) begin
          q_ui.push_back(i);
          q_ud.push_back(a);
        end
      end
      if (d == 0) begin
        vexp = inc ? i + 1 : i;
        break;
      end
      ptr = d;
    end
    @(negedge clk);
    remaining = 16'(rem); incl_mode = inc; chain_mode = chn; upd_mode = upd;
    base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R11: a second start mid-vector with other settings must change nothing
      repeat (2) @(negedge clk);
      remaining = 16'd1; chain_mode = ~chn; base_addr = 32'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " done seen"}, W'(done), 1);
    chk({tag, " vl_out"}, W'(vl_out), W'(vexp));
    @(negedge clk);
    chk("R10 done single pulse", W'(done), 0);
    chk("R10 vl_out holds", W'(vl_out), W'(vexp));
    chk({tag, " R7 nothing left pending"},
        W'(q_addr.size() + q_wbi.size() + q_ui.size()), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(negedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 12; i++) memm[32'h100 + 4 * i] = 32'h11 * (i + 1);
    memm[32'h200] = 32'h65; memm[32'h204] = 32'h6c; memm[32'h208] = 32'h0;
    memm[32'h20c] = 32'h78; memm[32'h210] = 32'h79;
    memm[32'h300] = 32'h0;  memm[32'h304] = 32'h42;
    memm[32'h408] = 32'h500; memm[32'h508] = 32'h600;
    memm[32'h608] = 32'h700; memm[32'h708] = 32'h0;
    memm[32'h808] = 32'h900; memm[32'h908] = 32'ha00; memm[32'ha08] = 32'hb00;
    memm[32'hb08] = 32'hc00;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", W'(mem_req), 0);
    chk("R1 wb_valid", W'(wb_valid), 0);
    chk("R1 upd_valid", W'(upd_valid), 0);
    chk("R1 done", W'(done), 0);
    chk("R1 vl_out", W'(vl_out), 0);

    run_case(5, 0, 0, 0, 32'h100, "R4 R3 all nonzero", 0);
    run_case(12, 1, 0, 0, 32'h100, "R2 clipped to MAXVL", 0);
    run_case(5, 0, 0, 0, 32'h200, "R5 R7 drop zero", 0);
    run_case(5, 1, 0, 0, 32'h200, "R6 R7 keep zero", 0);
    run_case(4, 0, 0, 0, 32'h300, "R5 zero at first", 0);
    run_case(4, 1, 0, 0, 32'h300, "R6 zero at first", 0);
    run_case(8, 1, 1, 0, 32'h400, "R8 chain keep", 0);
    run_case(8, 0, 1, 0, 32'h400, "R8 chain drop", 0);
    run_case(8, 1, 1, 1, 32'h400, "R9 chain update keep", 0);
    run_case(8, 0, 1, 1, 32'h400, "R9 chain update drop", 0);
    run_case(3, 0, 1, 1, 32'h800, "R8 R9 chain clipped", 0);
    run_case(0, 0, 0, 0, 32'h100, "R2 zero length", 0);
    run_case(6, 0, 0, 0, 32'h100, "R11 start while busy", 1);

    // R11: stray response strobe while idle must write nothing
    cur_tag = "R11 stray response";
    @(negedge clk);
    inject = 1'b1;
    @(negedge clk);
    inject = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 stray response vl_out", W'(vl_out), 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule